// File: doc/BRIEF.md
# Multi-Format Serial Audio Slave Receiver

This block receives serial audio from an external master that drives the bit clock and the word/frame select line. It brings the bit clock, the frame line and the data line into the system clock domain. It then finds slot and frame boundaries according to the selected framing style and shifts each slot into a parallel word. Four framing styles are supported:

- two-channel with a one-bit data delay,
- two-channel left-justified,
- multi-slot with a short frame pulse,
- multi-slot with a long frame pulse.

Each finished word appears for one system clock cycle on a valid output, along with its slot index. A sticky flag reports frames that ended before every configured slot was received.

The system clock must run at least four times faster than the bit clock. Slot words are either 16 or 24 bits wide. The block has no output buffering: the consumer must take each word in the cycle that it is valid.

Top module: `aud_rx_slave`

## Requirements
- R1: Data is sampled on rising bit-clock edges, most significant bit first. When `wide_sel`=0 a word is 16 bits, sits in `word_data[15:0]`, and `word_data[23:16]` is zero.
- R2: With `fmt_sel`=0 (delayed two-channel), a change of the frame line opens a slot. Its MSB is taken on the bit-clock rising edge after the one where the change is seen. Frame line low gives slot 0 (left) and high gives slot 1 (right). A high-to-low change is a frame start.
- R3: With `fmt_sel`=1 (left-justified), the MSB is the bit sampled on the same rising edge on which the frame-line change is seen. Slot mapping and frame start are as in R2.
- R4: With `fmt_sel`=2 (short pulse) or `fmt_sel`=3 (long pulse), only a low-to-high change of the frame line starts a frame. That edge carries the MSB of slot 0, and the length of the high pulse has no effect.
- R5: In `fmt_sel` 2 and 3, slots of the configured width follow each other with no gap. Their count is `slot_cfg`, numbered from 0. A value of 0 acts as 1 and a value above 6 acts as 6.
- R6: Bits after the last bit of a slot, up to the next slot or frame boundary, are ignored. This includes every bit after the last configured slot of a multi-slot frame.
- R7: If a frame start arrives before the current frame has delivered all its slots, `frame_err` is set. The slot count is 2 in `fmt_sel` 0/1 and the effective `slot_cfg` in 2/3. The flag stays set until reset, and capture restarts at slot 0 of the new frame.
- R8: `word_valid` is a single-cycle pulse per word. After reset, `word_valid` and `frame_err` are 0.
- R9: When `wide_sel`=1, words are 24 bits and fill `word_data[23:0]`.
- R10: Slot boundaries and bits seen before the first frame start after reset produce no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_sel | input | 2 | Framing style: 0 delayed two-channel, 1 left-justified, 2 short pulse, 3 long pulse |
| wide_sel | input | 1 | 0 selects 16-bit slots, 1 selects 24-bit slots |
| slot_cfg | input | 3 | Slots per frame in multi-slot styles |
| sck_in | input | 1 | External bit clock (asynchronous) |
| ws_in | input | 1 | External frame/channel select (asynchronous) |
| sd_in | input | 1 | Serial data (asynchronous) |
| word_valid | output | 1 | One-cycle strobe for a finished word |
| word_data | output | 24 | Received word, right-aligned |
| word_slot | output | 3 | Slot index of the word |
| frame_err | output | 1 | Sticky short-frame flag |

## Verification
The hardest case to reach is a multi-slot frame cut short in the middle of a later slot. After slot 1 completes, the receiver has already moved on to slot 2. The next rising frame edge must then both raise the error flag and discard the partial slot 2 word.

The stimulus first sends a full frame and checks that the flag is still clear. It then sends a frame carrying only two of four slots, and checks again before the next frame pulse arrives. Finally it sends a full frame and expects the flag to be set, with the scoreboard receiving slots 0 to 3 in order.

The bench also fills the padding bits after each slot with ones, so that any capture past the slot width shows up as a data mismatch.

// File: rtl/aud_rx_pkg.sv
// Package: shared encodings for the serial audio slave receiver.
package aud_rx_pkg;

    // Framing style selected by the fmt_sel input.
    typedef enum logic [1:0] {
        FMT_DELAYED = 2'd0,
        FMT_LEFTJ   = 2'd1,
        FMT_PULSE_S = 2'd2,
        FMT_PULSE_L = 2'd3
    } aud_fmt_e;

    // True for the multi-slot styles, where the frame edge is a rising pulse.
    function automatic logic fmt_is_multislot(input aud_fmt_e f);
        return (f == FMT_PULSE_S) || (f == FMT_PULSE_L);
    endfunction

endpackage

// File: rtl/aud_rx_sync.sv
// Module: aud_rx_sync
// Brings a bundle of asynchronous single-bit inputs into the clk domain
// through a chain of STAGES flops per bit. Assumes each bit is independent;
// bits that change together may land one cycle apart.
module aud_rx_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage: capture the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_async;
    end

    // Remaining stages: one flop per stage, built by generate.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/aud_rx_frame_det.sv
// Module: aud_rx_frame_det
// Turns the synchronized frame line into slot-boundary events aligned with
// bit ticks. The bit sampled on a tick that carries a boundary is the MSB of
// the new slot. The first tick after reset only records the line level.
// Assumes bit_tick is a single-cycle pulse per bit-clock rising edge.
module aud_rx_frame_det
    import aud_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_tick,
    input  logic     ws_bit,
    input  aud_fmt_e fmt,
    output logic     bnd,
    output logic     bnd_fs,
    output logic     bnd_right
);
    logic primed;
    logic ws_prev;
    logic dly_pend;
    logic dly_lvl;
    logic ws_edge;
    logic lvl;

    assign ws_edge = bit_tick && primed && (ws_bit != ws_prev);

    // Track the line level seen on the previous tick and the one-bit delayed event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed   <= 1'b0;
            ws_prev  <= 1'b0;
            dly_pend <= 1'b0;
            dly_lvl  <= 1'b0;
        end else if (bit_tick) begin
            primed   <= 1'b1;
            ws_prev  <= ws_bit;
            dly_pend <= (fmt == FMT_DELAYED) && ws_edge;
            dly_lvl  <= ws_bit;
        end
    end

    // Select the boundary rule for the current framing style.
    always_comb begin
        bnd = 1'b0;
        lvl = 1'b0;
        unique case (fmt)
            FMT_DELAYED: begin
                bnd = bit_tick && dly_pend;
                lvl = dly_lvl;
            end
            FMT_LEFTJ: begin
                bnd = ws_edge;
                lvl = ws_bit;
            end
            default: begin
                bnd = ws_edge && ws_bit;
                lvl = 1'b0;
            end
        endcase
    end

    assign bnd_fs    = bnd && !lvl;
    assign bnd_right = lvl;

    // R4: in the pulse styles a frame start is only ever raised while the line is high.
    assert_pulse_rise_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_is_multislot(fmt) && bnd) |-> (ws_bit && !ws_prev));

    // R2: a delayed boundary follows a tick on which the line changed.
    assert_delay_one_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_DELAYED && bnd) |-> dly_pend);
endmodule

// File: rtl/aud_rx_slot_cap.sv
// Module: aud_rx_slot_cap
// Shifts serial bits into slot words, emits one word per finished slot and
// checks frame completeness. Multi-slot styles chain slots back to back up to
// slot_lim. Assumes slot_lim is already clamped to 1..MAX_SLOTS and that the
// width selection does not change inside a frame.
module aud_rx_slot_cap #(
    parameter int unsigned WIDE_W    = 24,
    parameter int unsigned NARROW_W  = 16,
    parameter int unsigned MAX_SLOTS = 6,
    localparam int unsigned IDX_W    = $clog2(MAX_SLOTS),
    localparam int unsigned CNT_W    = $clog2(MAX_SLOTS + 1),
    localparam int unsigned BC_W     = $clog2(WIDE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              sd_bit,
    input  logic              bnd,
    input  logic              bnd_fs,
    input  logic [IDX_W-1:0]  bnd_slot,
    input  logic              is_multi,
    input  logic              wide,
    input  logic [CNT_W-1:0]  slot_lim,
    output logic              out_valid,
    output logic [WIDE_W-1:0] out_data,
    output logic [IDX_W-1:0]  out_slot,
    output logic              frame_err
);
    logic              synced;
    logic              active;
    logic              auto_next;
    logic [BC_W-1:0]   bitcnt;
    logic [WIDE_W-1:0] shreg;
    logic [IDX_W-1:0]  cur_slot;
    logic [CNT_W-1:0]  words;

    logic [BC_W-1:0]   width_now;
    logic [IDX_W-1:0]  next_slot;
    logic              start_req;
    logic [IDX_W-1:0]  start_slot;
    logic              finish;
    logic [WIDE_W-1:0] shift_val;
    logic              more_slots;

    // Decode the current slot width and the next-slot conditions.
    always_comb begin
        width_now  = wide ? BC_W'(WIDE_W) : BC_W'(NARROW_W);
        next_slot  = cur_slot + 1'b1;
        start_req  = bit_tick && (bnd ? (synced || bnd_fs) : auto_next);
        start_slot = bnd ? bnd_slot : next_slot;
        finish     = bit_tick && !start_req && active && ((bitcnt + 1'b1) == width_now);
        shift_val  = {shreg[WIDE_W-2:0], sd_bit};
        more_slots = ({1'b0, next_slot} < {1'b0, slot_lim});
    end

    // Frame tracking: lock on the first frame start and flag short frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced    <= 1'b0;
            frame_err <= 1'b0;
        end else if (bit_tick && bnd && bnd_fs) begin
            synced <= 1'b1;
            if (synced && (words < slot_lim)) frame_err <= 1'b1;
        end
    end

    // Shift engine: open slots, collect bits, and emit finished words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            auto_next <= 1'b0;
            bitcnt    <= '0;
            shreg     <= '0;
            cur_slot  <= '0;
            words     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_slot  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (bit_tick) auto_next <= 1'b0;
            if (bit_tick && bnd && bnd_fs) words <= '0;
            if (start_req) begin
                active   <= 1'b1;
                bitcnt   <= BC_W'(1);
                shreg    <= WIDE_W'(sd_bit);
                cur_slot <= start_slot;
            end else if (bit_tick && active) begin
                shreg  <= shift_val;
                bitcnt <= bitcnt + 1'b1;
                if (finish) begin
                    active    <= 1'b0;
                    out_valid <= 1'b1;
                    out_data  <= shift_val;
                    out_slot  <= cur_slot;
                    auto_next <= is_multi && more_slots;
                    if (words != CNT_W'(MAX_SLOTS)) words <= words + 1'b1;
                end
            end
        end
    end

    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

    assert_slot_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({1'b0, out_slot} < {1'b0, $past(slot_lim)}));

    assert_bitcnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (bitcnt <= width_now));

    assert_narrow_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !wide) |-> (out_data[WIDE_W-1:NARROW_W] == '0));

    assert_no_word_unsynced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> synced);
endmodule

// File: rtl/aud_rx_slave.sv
// Module: aud_rx_slave (top)
// Serial audio slave receiver for four framing styles. It synchronizes the
// external clock, frame and data lines, detects bit-clock rising edges and
// hands bits to the boundary detector and the slot capture engine.
// Assumes clk runs at least four times faster than the external bit clock.
module aud_rx_slave
    import aud_rx_pkg::*;
#(
    parameter int unsigned WIDE_W      = 24,
    parameter int unsigned NARROW_W    = 16,
    parameter int unsigned MAX_SLOTS   = 6,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned IDX_W      = $clog2(MAX_SLOTS),
    localparam int unsigned CNT_W      = $clog2(MAX_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_sel,
    input  logic              wide_sel,
    input  logic [CNT_W-1:0]  slot_cfg,
    input  logic              sck_in,
    input  logic              ws_in,
    input  logic              sd_in,
    output logic              word_valid,
    output logic [WIDE_W-1:0] word_data,
    output logic [IDX_W-1:0]  word_slot,
    output logic              frame_err
);
    logic [2:0]       line_sync;
    logic             sck_s, ws_s, sd_s;
    logic             sck_d;
    logic             bit_tick;
    aud_fmt_e         fmt;
    logic             is_multi;
    logic [CNT_W-1:0] slot_lim;
    logic             bnd, bnd_fs, bnd_right;

    aud_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sck_in, ws_in, sd_in}),
        .d_sync  (line_sync)
    );

    assign {sck_s, ws_s, sd_s} = line_sync;

    // Delay the synchronized bit clock one cycle to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign bit_tick = sck_s && !sck_d;
    assign fmt      = aud_fmt_e'(fmt_sel);
    assign is_multi = fmt_is_multislot(fmt);

    // Clamp the configured slot count; two-channel styles always use two.
    always_comb begin
        if (!is_multi)                          slot_lim = CNT_W'(2);
        else if (slot_cfg == '0)                slot_lim = CNT_W'(1);
        else if (slot_cfg > CNT_W'(MAX_SLOTS))  slot_lim = CNT_W'(MAX_SLOTS);
        else                                    slot_lim = slot_cfg;
    end

    aud_rx_frame_det u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .ws_bit    (ws_s),
        .fmt       (fmt),
        .bnd       (bnd),
        .bnd_fs    (bnd_fs),
        .bnd_right (bnd_right)
    );

    aud_rx_slot_cap #(
        .WIDE_W    (WIDE_W),
        .NARROW_W  (NARROW_W),
        .MAX_SLOTS (MAX_SLOTS)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .sd_bit    (sd_s),
        .bnd       (bnd),
        .bnd_fs    (bnd_fs),
        .bnd_slot  (IDX_W'(bnd_right)),
        .is_multi  (is_multi),
        .wide      (wide_sel),
        .slot_lim  (slot_lim),
        .out_valid (word_valid),
        .out_data  (word_data),
        .out_slot  (word_slot),
        .frame_err (frame_err)
    );

    // R8: a bit tick needs a low sample of the bit clock in the previous cycle.
    assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);
endmodule

// File: tb/aud_rx_slave_tb.sv
// Scoreboard bench: driver tasks push expected {slot,data} items, a monitor pops them.
module aud_rx_slave_tb;
    localparam int CLK_NS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic        wide_sel = 1'b0;
    logic [2:0]  slot_cfg = 3'd2;
    logic        sck_in = 1'b0;
    logic        ws_in = 1'b0;
    logic        sd_in = 1'b0;
    logic        word_valid;
    logic [23:0] word_data;
    logic [2:0]  word_slot;
    logic        frame_err;

    int          checks = 0;
    int          errors = 0;
    int          seed = 1;
    string       cur_req = "R1";
    logic [26:0] exp_q [$];

    always #(CLK_NS / 2.0) clk = ~clk;

    aud_rx_slave u_dut (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .wide_sel(wide_sel),
        .slot_cfg(slot_cfg), .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
        .word_valid(word_valid), .word_data(word_data), .word_slot(word_slot),
        .frame_err(frame_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [23:0] gen_word(input int n, input int w);
        logic [31:0] v;
        v = 32'(n) * 32'h9E3779B1 ^ 32'h5A5AC3C3;
        return (w == 24) ? v[23:0] : {8'h00, v[15:0]};
    endfunction

    // Monitor: compare each output word with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_req, " unexpected word"}, int'({word_slot, word_data}), 0);
            end else begin
                logic [26:0] e;
                e = exp_q.pop_front();
                check({word_slot, word_data} == e, cur_req, int'({word_slot, word_data}), int'(e));
            end
        end
    end

    task automatic drive_bit(input logic w, input logic d);
        ws_in = w;
        sd_in = d;
        repeat (4) @(negedge clk);
        sck_in = 1'b1;
        repeat (4) @(negedge clk);
        sck_in = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sck_in = 1'b0;
        ws_in = 1'b0;
        sd_in = 1'b0;
        exp_q.delete();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain(input string req);
        repeat (24) @(negedge clk);
        check(exp_q.size() == 0, {req, " all expected words received"}, exp_q.size(), 0);
    endtask

    // Two-channel frames of 32 bit clocks per slot; padding bits are ones.
    task automatic run_two_ch(input int fm, input int w, input int nfr, input bit preroll);
        fmt_sel = 2'(fm);
        wide_sel = (w == 24);
        if (preroll) begin
            repeat (2) drive_bit(1'b0, 1'b0);
            repeat (32) drive_bit(1'b1, 1'b1);
        end else begin
            repeat (2) drive_bit(1'b1, 1'b0);
        end
        for (int fr = 0; fr < nfr; fr++) begin
            logic [23:0] lw, rw;
            lw = gen_word(seed++, w);
            rw = gen_word(seed++, w);
            exp_q.push_back({3'd0, lw});
            exp_q.push_back({3'd1, rw});
            for (int i = 0; i < 64; i++) begin
                int p, b;
                logic bv;
                p = (fm == 0) ? (i + 63) % 64 : i;
                b = p % 32;
                bv = (b < w) ? ((p >= 32) ? rw[w-1-b] : lw[w-1-b]) : 1'b1;
                drive_bit(i >= 32, bv);
            end
        end
        repeat (4) drive_bit(1'b1, 1'b0);
    endtask

    // Multi-slot frames: nsl slots driven, frame length flen bits.
    task automatic run_multi(input int fm, input int w, input int cfg, input int nsl,
                             input int flen, input int nfr);
        int eff;
        fmt_sel = 2'(fm);
        wide_sel = (w == 24);
        slot_cfg = 3'(cfg);
        eff = (cfg == 0) ? 1 : (cfg > 6) ? 6 : cfg;
        repeat (2) drive_bit(1'b0, 1'b0);
        for (int fr = 0; fr < nfr; fr++) begin
            logic [23:0] wv [8];
            for (int k = 0; k < 8; k++) begin
                wv[k] = gen_word(seed++, w);
                if (k < nsl && k < eff) exp_q.push_back({3'(k), wv[k]});
            end
            for (int i = 0; i < flen; i++) begin
                int k, b;
                logic wsv, bv;
                k = i / w;
                b = i % w;
                wsv = (fm == 3) ? (i < w) : (i == 0);
                bv = (k < nsl && k < 8) ? wv[k][w-1-b] : 1'b1;
                drive_bit(wsv, bv);
            end
        end
        repeat (4) drive_bit(1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R8: reset state
        check(word_valid == 1'b0, "R8 valid after reset", word_valid, 0);
        check(frame_err == 1'b0, "R8 err after reset", frame_err, 0);

        // R2 R10 R6 R1: delayed style, 16-bit, with a right slot before the first frame
        cur_req = "R2 R10 R6 R1";
        run_two_ch(0, 16, 3, 1'b1);
        drain("R2");
        check(frame_err == 1'b0, "R2 no frame error", frame_err, 0);

        // R9: delayed style, 24-bit
        do_reset();
        cur_req = "R9 R2";
        run_two_ch(0, 24, 2, 1'b0);
        drain("R9");

        // R3: left-justified, 16 and 24 bit
        do_reset();
        cur_req = "R3 R6";
        run_two_ch(1, 16, 2, 1'b1);
        drain("R3");
        do_reset();
        cur_req = "R3 R9";
        run_two_ch(1, 24, 1, 1'b0);
        drain("R3");

        // R4 R5: short pulse, four 16-bit slots with padding
        do_reset();
        cur_req = "R4 R5";
        run_multi(2, 16, 4, 4, 70, 2);
        drain("R4");
        check(frame_err == 1'b0, "R4 no frame error", frame_err, 0);

        // R4: long pulse, two 24-bit slots
        do_reset();
        cur_req = "R4 R9";
        run_multi(3, 24, 2, 2, 50, 2);
        drain("R4");

        // R5: six slots, clamp of 7 to 6, clamp of 0 to 1
        do_reset();
        cur_req = "R5";
        run_multi(2, 16, 6, 6, 100, 1);
        drain("R5");
        do_reset();
        cur_req = "R5 R6";
        run_multi(2, 16, 7, 7, 114, 1);
        drain("R5");
        do_reset();
        cur_req = "R5 R6";
        run_multi(3, 16, 0, 2, 34, 2);
        drain("R5");
        check(frame_err == 1'b0, "R5 no error with one slot", frame_err, 0);

        // R7: short frame, then resync
        do_reset();
        cur_req = "R7";
        run_multi(3, 16, 4, 4, 70, 1);
        drain("R7");
        check(frame_err == 1'b0, "R7 clear after full frame", frame_err, 0);
        run_multi(3, 16, 4, 2, 34, 1);
        drain("R7");
        check(frame_err == 1'b0, "R7 clear before next frame start", frame_err, 0);
        run_multi(3, 16, 4, 4, 70, 1);
        drain("R7");
        check(frame_err == 1'b1, "R7 set after short frame", frame_err, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule